// File: doc/BRIEF.md
# Dual X/Y Operand Address Router

This block sits between the address generators of a processor core and a data memory that is split into two regions, X and Y. The Y region is a contiguous window that lies entirely inside the X address range, so the two regions together form one linear map. The block accepts up to two operand fetch requests per cycle. Each request carries a 16-bit byte pointer and the index of the register that supplied it. For each port, the block produces a registered word address and a single outcome flag, one cycle after the request.

Outside multiply-accumulate mode, only the X port is served, and it reaches the entire address space, including the Y window. Byte fetches may use odd addresses. Word fetches must be even.

In multiply-accumulate mode both ports run at the same time, and every fetch is word sized:
- The X port accepts pointers only from registers 8 and 9, and it must stay out of the Y window.
- The Y port accepts pointers only from registers 10 and 11, and it must land inside the Y window.

A fetch that breaks one of these rules is marked as forced-zero, meaning the operand reads as 0x0000. An odd word address is flagged as misaligned.

Top module: `xy_operand_router`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, all six outcome flags are 0 and both word addresses are 0.
- R2: With `mac_en`=0, an X request with any source index and any pointer, Y window included, gives `xo_ok`=1 one cycle later. `xo_addr` equals pointer bits [15:1].
- R3: With `mac_en`=0 and an odd X pointer, the outcome depends on `byte_op`. If `byte_op`=1 the result is `xo_ok`=1. If `byte_op`=0 the result is `xo_odd`=1 with `xo_ok`=0.
- R4: With `mac_en`=0, a Y request is ignored: `yo_ok`, `yo_zero` and `yo_odd` stay 0.
- R5: With `mac_en`=1, an X request from source 8 or 9 gives `xo_ok`=1, provided the pointer is even and outside [Y_BASE, Y_LIMIT] (default 0x0800..0x0FFF).
- R6: With `mac_en`=1, an X request from any source other than 8 or 9 gives `xo_zero`=1 and `xo_ok`=0, whatever the pointer's alignment.
- R7: With `mac_en`=1, an X pointer inside [Y_BASE, Y_LIMIT] gives `xo_zero`=1, including both end words. Pointers just outside the window are accepted.
- R8: With `mac_en`=1, a Y request from source 10 or 11 with an even pointer inside the window gives `yo_ok`=1, and `yo_addr` equals pointer bits [15:1]. This holds while the X port is served in the same cycle.
- R9: With `mac_en`=1, a Y request from any source other than 10 or 11 gives `yo_zero`=1.
- R10: With `mac_en`=1, a Y pointer outside [Y_BASE, Y_LIMIT] gives `yo_zero`=1.
- R11: With `mac_en`=1, an odd pointer from a legal source and in a legal range gives the port's misaligned flag, and the ok flag stays 0. This holds even with `byte_op`=1, because these fetches are word only.
- R12: A port with no request in a cycle shows all three of its outcome flags at 0 in the following cycle. At most one flag per port is ever 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | Multiply-accumulate mode |
| byte_op | input | 1 | Byte-sized access (outside multiply-accumulate mode only) |
| xf_req | input | 1 | X port fetch strobe |
| xf_ptr | input | 16 | X port byte pointer |
| xf_src | input | 4 | Index of the register that supplied the X pointer |
| yf_req | input | 1 | Y port fetch strobe |
| yf_ptr | input | 16 | Y port byte pointer |
| yf_src | input | 4 | Index of the register that supplied the Y pointer |
| xo_addr | output | 15 | X port word address |
| xo_ok | output | 1 | X fetch accepted |
| xo_zero | output | 1 | X fetch illegal, operand reads as zero |
| xo_odd | output | 1 | X word fetch misaligned |
| yo_addr | output | 15 | Y port word address |
| yo_ok | output | 1 | Y fetch accepted |
| yo_zero | output | 1 | Y fetch illegal, operand reads as zero |
| yo_odd | output | 1 | Y word fetch misaligned |

## Verification
The only state in the block is the registered outcome of each port. A wrong value therefore shows up exactly one cycle after the offending request, as a wrong flag or a wrong word address on that port. The outcome does not linger past the next request. The directed scenarios aim at the decision points where a fault would appear:
- each side of both window boundaries;
- legal and illegal source indices;
- odd pointers with the byte flag set, in each mode;
- concurrent use of both ports.

// File: rtl/xy_operand_router.sv
module xy_operand_router #(
  parameter int AW = 16,
  parameter int RW = 4,
  parameter logic [15:0] Y_BASE  = 16'h0800,
  parameter logic [15:0] Y_LIMIT = 16'h0FFF,
  parameter int X_SRC = 8,
  parameter int Y_SRC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_en,
  input  logic          byte_op,
  input  logic          xf_req,
  input  logic [AW-1:0] xf_ptr,
  input  logic [RW-1:0] xf_src,
  input  logic          yf_req,
  input  logic [AW-1:0] yf_ptr,
  input  logic [RW-1:0] yf_src,
  output logic [AW-2:0] xo_addr,
  output logic          xo_ok,
  output logic          xo_zero,
  output logic          xo_odd,
  output logic [AW-2:0] yo_addr,
  output logic          yo_ok,
  output logic          yo_zero,
  output logic          yo_odd
);
  localparam logic [AW-1:0] LO = AW'(Y_BASE);
  localparam logic [AW-1:0] HI = AW'(Y_LIMIT);

  logic x_src_ok, y_src_ok, x_in_win, y_in_win;
  logic x_bar, y_bar, x_mis, y_mis, y_act;

  assign x_src_ok = (xf_src == RW'(X_SRC)) || (xf_src == RW'(X_SRC + 1));
  assign y_src_ok = (yf_src == RW'(Y_SRC)) || (yf_src == RW'(Y_SRC + 1));
  assign x_in_win = (xf_ptr >= LO) && (xf_ptr <= HI);
  assign y_in_win = (yf_ptr >= LO) && (yf_ptr <= HI);

  assign x_bar = mac_en && (!x_src_ok || x_in_win);
  assign x_mis = xf_ptr[0] && (mac_en || !byte_op);
  assign y_act = mac_en && yf_req;
  assign y_bar = !y_src_ok || !y_in_win;
  assign y_mis = yf_ptr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xo_addr <= '0;
      xo_ok   <= 1'b0;
      xo_zero <= 1'b0;
      xo_odd  <= 1'b0;
    end else begin
      xo_ok   <= xf_req && !x_bar && !x_mis;
      xo_zero <= xf_req && x_bar;
      xo_odd  <= xf_req && !x_bar && x_mis;
      if (xf_req) xo_addr <= xf_ptr[AW-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yo_addr <= '0;
      yo_ok   <= 1'b0;
      yo_zero <= 1'b0;
      yo_odd  <= 1'b0;
    end else begin
      yo_ok   <= y_act && !y_bar && !y_mis;
      yo_zero <= y_act && y_bar;
      yo_odd  <= y_act && !y_bar && y_mis;
      if (y_act) yo_addr <= yf_ptr[AW-1:1];
    end
  end
endmodule

module xy_operand_router_chk #(
  parameter int AW = 16,
  parameter int RW = 4,
  parameter logic [15:0] Y_BASE  = 16'h0800,
  parameter logic [15:0] Y_LIMIT = 16'h0FFF,
  parameter int X_SRC = 8,
  parameter int Y_SRC = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mac_en,
  input logic          byte_op,
  input logic          xf_req,
  input logic [AW-1:0] xf_ptr,
  input logic [RW-1:0] xf_src,
  input logic          yf_req,
  input logic [AW-1:0] yf_ptr,
  input logic [RW-1:0] yf_src,
  input logic [AW-2:0] xo_addr,
  input logic          xo_ok,
  input logic          xo_zero,
  input logic          xo_odd,
  input logic [AW-2:0] yo_addr,
  input logic          yo_ok,
  input logic          yo_zero,
  input logic          yo_odd
);
  logic xs_legal, ys_legal, xw, yw;
  assign xs_legal = (xf_src == RW'(X_SRC)) || (xf_src == RW'(X_SRC + 1));
  assign ys_legal = (yf_src == RW'(Y_SRC)) || (yf_src == RW'(Y_SRC + 1));
  assign xw = (xf_ptr >= AW'(Y_BASE)) && (xf_ptr <= AW'(Y_LIMIT));
  assign yw = (yf_ptr >= AW'(Y_BASE)) && (yf_ptr <= AW'(Y_LIMIT));

  AST_X_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xo_ok, xo_zero, xo_odd}) <= 1);  // R12
  AST_Y_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({yo_ok, yo_zero, yo_odd}) <= 1);  // R12
  AST_X_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xf_req |=> !xo_ok && !xo_zero && !xo_odd);  // R12
  AST_X_LINEAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    xf_req |=> xo_addr == $past(xf_ptr[AW-1:1]));  // R2
  AST_X_BYTE_NO_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_en && xf_req && byte_op |=> xo_ok);  // R3
  AST_Y_IDLE_OUTSIDE_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_en |=> !yo_ok && !yo_zero && !yo_odd);  // R4
  AST_X_BAD_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && xf_req && !xs_legal |=> xo_zero);  // R6
  AST_X_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && xf_req && xw |=> xo_zero);  // R7
  AST_Y_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && yf_req |=> yo_addr == $past(yf_ptr[AW-1:1]));  // R8
  AST_Y_BAD_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && yf_req && !ys_legal |=> yo_zero);  // R9
  AST_Y_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && yf_req && !yw |=> yo_zero);  // R10
  AST_Y_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en && yf_req && ys_legal && yw && yf_ptr[0] |=> yo_odd);  // R11
endmodule

bind xy_operand_router xy_operand_router_chk #(
  .AW(AW), .RW(RW), .Y_BASE(Y_BASE), .Y_LIMIT(Y_LIMIT), .X_SRC(X_SRC), .Y_SRC(Y_SRC)
) u_chk (.*);

// File: tb/xy_operand_router_test.sv
module xy_operand_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mac_en = 1'b0, byte_op = 1'b0;
  logic xf_req = 1'b0, yf_req = 1'b0;
  logic [15:0] xf_ptr = '0, yf_ptr = '0;
  logic [3:0] xf_src = '0, yf_src = '0;
  logic [14:0] xo_addr, yo_addr;
  logic xo_ok, xo_zero, xo_odd, yo_ok, yo_zero, yo_odd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xy_operand_router uut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic fetch(logic m, logic b, logic xr, logic [15:0] xp, logic [3:0] xs,
                       logic yr, logic [15:0] yp, logic [3:0] ys);
    mac_en = m; byte_op = b;
    xf_req = xr; xf_ptr = xp; xf_src = xs;
    yf_req = yr; yf_ptr = yp; yf_src = ys;
    @(negedge clk);
    xf_req = 1'b0; yf_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 x flags", {13'd0, xo_ok, xo_zero, xo_odd}, 16'd0);
    chk("R1 y flags", {13'd0, yo_ok, yo_zero, yo_odd}, 16'd0);
    chk("R1 x addr", {1'b0, xo_addr}, 16'd0);
    chk("R1 y addr", {1'b0, yo_addr}, 16'd0);
  endtask

  task automatic t_linear();
    fetch(0, 0, 1, 16'h0900, 4'd3, 0, 0, 0);
    chk("R2 flags in window", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    chk("R2 addr", {1'b0, xo_addr}, 16'h0480);
    fetch(0, 0, 1, 16'hFFFE, 4'd12, 0, 0, 0);
    chk("R2 top flags", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    chk("R2 top addr", {1'b0, xo_addr}, 16'h7FFF);
  endtask

  task automatic t_byte();
    fetch(0, 1, 1, 16'h0123, 4'd1, 0, 0, 0);
    chk("R3 byte odd", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    chk("R3 byte addr", {1'b0, xo_addr}, 16'h0091);
    fetch(0, 0, 1, 16'h0123, 4'd1, 0, 0, 0);
    chk("R3 word odd", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b001);
  endtask

  task automatic t_y_ignored();
    fetch(0, 0, 0, 0, 0, 1, 16'h0900, 4'd10);
    chk("R4 y ignored", {13'd0, yo_ok, yo_zero, yo_odd}, 16'd0);
    chk("R4 y addr held", {1'b0, yo_addr}, 16'd0);
  endtask

  task automatic t_mac_x();
    fetch(1, 0, 1, 16'h0200, 4'd8, 0, 0, 0);
    chk("R5 src8", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    chk("R5 addr", {1'b0, xo_addr}, 16'h0100);
    fetch(1, 0, 1, 16'h2000, 4'd9, 0, 0, 0);
    chk("R5 src9", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    fetch(1, 0, 1, 16'h0200, 4'd10, 0, 0, 0);
    chk("R6 src10 on x", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b010);
    fetch(1, 0, 1, 16'h0201, 4'd0, 0, 0, 0);
    chk("R6 src0 odd on x", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b010);
  endtask

  task automatic t_mac_window();
    fetch(1, 0, 1, 16'h0800, 4'd8, 0, 0, 0);
    chk("R7 base", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b010);
    fetch(1, 0, 1, 16'h0FFE, 4'd9, 0, 0, 0);
    chk("R7 last word", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b010);
    fetch(1, 0, 1, 16'h07FE, 4'd8, 0, 0, 0);
    chk("R7 below", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    fetch(1, 0, 1, 16'h1000, 4'd8, 0, 0, 0);
    chk("R7 above", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
  endtask

  task automatic t_mac_y();
    fetch(1, 0, 1, 16'h0400, 4'd8, 1, 16'h0800, 4'd10);
    chk("R8 dual x", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b100);
    chk("R8 dual y", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b100);
    chk("R8 y addr", {1'b0, yo_addr}, 16'h0400);
    chk("R8 x addr", {1'b0, xo_addr}, 16'h0200);
    fetch(1, 0, 0, 0, 0, 1, 16'h0FFE, 4'd11);
    chk("R8 src11 end", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b100);
    fetch(1, 0, 0, 0, 0, 1, 16'h0900, 4'd8);
    chk("R9 src8 on y", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b010);
    fetch(1, 0, 0, 0, 0, 1, 16'h07FE, 4'd10);
    chk("R10 below", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b010);
    fetch(1, 0, 0, 0, 0, 1, 16'h1000, 4'd11);
    chk("R10 above", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b010);
  endtask

  task automatic t_odd();
    fetch(1, 1, 1, 16'h0201, 4'd8, 1, 16'h0803, 4'd11);
    chk("R11 x odd", {13'd0, xo_ok, xo_zero, xo_odd}, 16'b001);
    chk("R11 y odd", {13'd0, yo_ok, yo_zero, yo_odd}, 16'b001);
  endtask

  task automatic t_idle();
    fetch(1, 0, 0, 16'h0200, 4'd8, 0, 16'h0800, 4'd10);
    chk("R12 x idle", {13'd0, xo_ok, xo_zero, xo_odd}, 16'd0);
    chk("R12 y idle", {13'd0, yo_ok, yo_zero, yo_odd}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_byte();
    t_y_ignored();
    t_mac_x();
    t_mac_window();
    t_mac_y();
    t_odd();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule